// File: doc/BRIEF.md
# Nested Event Controller

This block arbitrates the events of a processor core over sixteen priority levels. Level 0 is the most urgent. The levels are assigned as follows:

- 0: emulation
- 1: reset
- 2: non-maskable interrupt
- 3: exception
- 4: a global interrupt-disable flag, not a real event
- 5: hardware error
- 6: core timer
- 7 to 15: general purpose

Requests arrive on a 16-bit request vector and on an exception port that carries a cause code. Each request is latched. The block then decides, in the same clock cycle, whether the core must enter that level. When it does, a one-cycle take strobe reports the level, the return address the core must save, and whether the reset vector replaces the level's own vector.

Nesting state is kept as a bitmap of levels in service, called the pending set. The most urgent in-service level, ignoring bits 0 and 4, is the current level. If no such level is in service, the core runs in user mode. Return requests name the kind of return instruction and carry the saved address. The block validates the return and then releases the level.

Software sees five 32-bit registers:

- override
- mask
- pending
- latch
- priority

There are also two operations: one clears the mask and reports the old mask, and one loads a new mask. A two-state machine has a run state, ST_RUN, and a frozen state, ST_FAULT. The transition ST_RUN to ST_FAULT fires on a double fault. ST_FAULT is left only through reset.

Top module: `event_ctrl`

## Requirements
- R1: After reset the mask register reads 0x1F, the pending register reads 0x12, the latch register reads 0, the core is in supervisor mode at current level 1, and `fatal` is low.
- R2: `cur_level` is the lowest set bit of the pending set excluding bits 0 and 4. `user_mode` is high, and `supervisor` is low, when no such bit is set.
- R3: Registers sit at word offsets override=0, mask=1, pending=2, latch=3, priority=4. A mask write keeps bits 0..4 set and loads bits 5..15 from the data. A priority write keeps only bits 0..4 of the data. The override register holds all 32 bits.
- R4: Writes to the pending register have no effect. A latch write clears the latch bits that are set both in the data and in 0xFFEE. An access with `reg_full_word` low raises `reg_err` and changes nothing.
- R5: Any raise sets its latch bit. Levels 0 and 1 are always taken. Levels 2 and 3 are taken only when more urgent than the current level. Otherwise the block enters ST_FAULT, holds `fatal` high and takes nothing more.
- R6: A request for level 5 or above stays latched and is not taken in any of these cases:
  - pending bit 4 is set outside user mode;
  - the level is masked;
  - the level is less urgent than the current level;
  - the level equals the current level while `selfnest_en` is low.
  Request bit 4 is ignored.
- R7: Taking a level sets its pending bit and clears its latch bit. For level 5 and above it also sets pending bit 4. The take outputs appear after the deciding edge. For levels 5..15 the return address is `cur_pc` with bit 0 set when the level equals the current level.
- R8: For a taken exception, the return address is `cur_pc` when the cause is 0x20 or more, and `next_pc` otherwise.
- R9: For levels 7..15, `take_vec_reset` is high when the level's override bit is set. For lower levels it is always low.
- R10: `ret_kind` is encoded as 0 interrupt, 1 exception, 2 NMI, 3 emulation. Each kind is legal only as follows:
  - exception return only at current level 3;
  - NMI return only at current level 2;
  - emulation return only with pending bit 0 set;
  - interrupt return only outside user mode and not at levels 2 or 3.
  An illegal return pulses `ill_res` and changes nothing.
- R11: A legal return pulses `ret_pc_valid` with `ret_pc` equal to `ret_addr` with bit 0 cleared. It clears the level's pending bit unless bit 0 of `ret_addr` is set. It clears pending bit 4 when the level is 1 or 5 and above.
- R12: Latched, unmasked requests are re-evaluated in the cycle that a mask write, a mask load or a return changes the state. Of several requests, the lowest-numbered level is taken and the rest stay latched.
- R13: The mask-clear operation reports the old mask on `cli_old_mask` and leaves only bits 0..4 set. The mask-load operation loads bits 5..15 from `sti_value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_req | input | 16 | Raise requests, one bit per level |
| exc_req | input | 1 | Exception request (level 3) |
| exc_cause | input | 6 | Cause code of the exception request |
| selfnest_en | input | 1 | Allows re-entry at the current level |
| cur_pc | input | 32 | Address of the current instruction |
| next_pc | input | 32 | Address of the following instruction |
| ret_req | input | 1 | Return-from-event request |
| ret_kind | input | 2 | Return kind (see R10) |
| ret_addr | input | 32 | Saved return address |
| cli_req | input | 1 | Clear maskable mask bits |
| sti_req | input | 1 | Load the mask |
| sti_value | input | 16 | Mask value for the load |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_full_word | input | 1 | Access is 32 bits wide |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| reg_err | output | 1 | Access width error |
| take_valid | output | 1 | Event taken |
| take_level | output | 4 | Level taken |
| take_ret_addr | output | 32 | Return address to save |
| take_vec_reset | output | 1 | Use the reset vector |
| ret_pc_valid | output | 1 | Legal return accepted |
| ret_pc | output | 32 | Address to resume at |
| ill_res | output | 1 | Illegal return detected |
| cli_old_mask | output | 16 | Mask before the last clear |
| fatal | output | 1 | Double fault, frozen |
| user_mode | output | 1 | No level in service |
| supervisor | output | 1 | A level is in service |
| cur_level | output | 4 | Current level (0 in user mode) |

## Verification
Single raises from user mode show that a level is entered directly. Raises made while a level is in service separate the three holding causes: the global-disable bit, the mask, and lower urgency. Two simultaneous requests show which level wins and that the loser stays latched until a return frees it. A request at the current level, taken only when `selfnest_en` rises, pins the nesting flag in the return address. Exceptions with cause codes on both sides of 0x20, and an exception raised while a more urgent level is in service, separate the two return-address choices from the double-fault path.

// File: rtl/event_ctrl_pkg.sv
package event_ctrl_pkg;
    localparam int unsigned NLVL = 16;
    localparam int unsigned LW   = 4;

    localparam logic [NLVL-1:0] LVL_UNMASK = 16'h001F;
    localparam logic [NLVL-1:0] LVL_W1C_OK = 16'hFFEE;
    localparam logic [NLVL-1:0] LVL_OVR_OK = 16'hFF80;
    localparam logic [NLVL-1:0] LVL_MODE_X = 16'h0011;
    localparam logic [NLVL-1:0] PEND_RESET = 16'h0012;

    localparam logic [2:0] OFF_OVR  = 3'd0;
    localparam logic [2:0] OFF_MASK = 3'd1;
    localparam logic [2:0] OFF_PEND = 3'd2;
    localparam logic [2:0] OFF_LAT  = 3'd3;
    localparam logic [2:0] OFF_PRIO = 3'd4;

    typedef enum logic [1:0] {
        RET_INT = 2'd0,
        RET_EXC = 2'd1,
        RET_NMI = 2'd2,
        RET_EMU = 2'd3
    } ret_kind_e;

    typedef enum logic {
        ST_RUN   = 1'b0,
        ST_FAULT = 1'b1
    } evc_state_e;
endpackage

// File: rtl/evc_lsb_find.sv
module evc_lsb_find #(
    parameter int unsigned W  = 16,
    parameter int unsigned IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/evc_cfg_regs.sv
module evc_cfg_regs
    import event_ctrl_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] ovr_q,
    output logic [DW-1:0] prio_q
);
    localparam logic [DW-1:0] PRIO_KEEP = DW'(LVL_UNMASK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q  <= '0;
            prio_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == OFF_OVR)  ovr_q  <= wr_data;
            if (wr_addr == OFF_PRIO) prio_q <= wr_data & PRIO_KEEP;
        end
    end

    assert_prio_high_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_q & ~PRIO_KEEP) == '0);
endmodule

// File: rtl/event_ctrl.sv
module event_ctrl
    import event_ctrl_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned CW = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NLVL-1:0] evt_req,
    input  logic            exc_req,
    input  logic [CW-1:0]   exc_cause,
    input  logic            selfnest_en,
    input  logic [DW-1:0]   cur_pc,
    input  logic [DW-1:0]   next_pc,
    input  logic            ret_req,
    input  logic [1:0]      ret_kind,
    input  logic [DW-1:0]   ret_addr,
    input  logic            cli_req,
    input  logic            sti_req,
    input  logic [NLVL-1:0] sti_value,
    input  logic            reg_wr,
    input  logic            reg_rd,
    input  logic            reg_full_word,
    input  logic [2:0]      reg_addr,
    input  logic [DW-1:0]   reg_wdata,
    output logic [DW-1:0]   reg_rdata,
    output logic            reg_err,
    output logic            take_valid,
    output logic [LW-1:0]   take_level,
    output logic [DW-1:0]   take_ret_addr,
    output logic            take_vec_reset,
    output logic            ret_pc_valid,
    output logic [DW-1:0]   ret_pc,
    output logic            ill_res,
    output logic [NLVL-1:0] cli_old_mask,
    output logic            fatal,
    output logic            user_mode,
    output logic            supervisor,
    output logic [LW-1:0]   cur_level
);
    localparam logic [CW-1:0] CAUSE_ERR_MIN = CW'(32);
    localparam logic [LW:0]   LVL_USER      = (LW+1)'(NLVL);

    evc_state_e      state_q, state_d;
    logic [NLVL-1:0] imask_q, ipend_q, ilat_q;
    logic [CW-1:0]   cause_q;
    logic [DW-1:0]   ovr_q, prio_q;

    logic            run, wr_ok;
    logic            now_found, aft_found, cand_found;
    logic [LW-1:0]   now_idx, aft_idx, cand_idx;
    logic [LW:0]     cur_a, cand5;
    logic [NLVL-1:0] imask_a, ipend_a, ilat_a, req_bits, ipend_n, ilat_n;
    logic            ret_ok, do_ret, bad_ret, do_take, dfault;
    logic [LW-1:0]   ret_lvl;
    logic [CW-1:0]   cause_now;
    logic [DW-1:0]   ret_save;
    ret_kind_e       rk;

    assign run   = (state_q == ST_RUN);
    assign wr_ok = run && reg_wr && reg_full_word;
    assign rk    = ret_kind_e'(ret_kind);

    evc_cfg_regs #(.DW(DW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_ok), .wr_addr(reg_addr),
        .wr_data(reg_wdata), .ovr_q(ovr_q), .prio_q(prio_q)
    );

    evc_lsb_find #(.W(NLVL), .IW(LW)) u_cur_now (
        .vec(ipend_q & ~LVL_MODE_X), .found(now_found), .idx(now_idx));
    evc_lsb_find #(.W(NLVL), .IW(LW)) u_cur_aft (
        .vec(ipend_a & ~LVL_MODE_X), .found(aft_found), .idx(aft_idx));
    evc_lsb_find #(.W(NLVL), .IW(LW)) u_cand (
        .vec(ilat_a & imask_a), .found(cand_found), .idx(cand_idx));

    // Return legality and its effect on the pending set.
    always_comb begin
        ret_lvl = now_idx;
        ret_ok  = 1'b0;
        unique case (rk)
            RET_EMU: begin ret_lvl = LW'(0); ret_ok = ipend_q[0]; end
            RET_NMI: begin ret_lvl = LW'(2); ret_ok = now_found && now_idx == LW'(2); end
            RET_EXC: begin ret_lvl = LW'(3); ret_ok = now_found && now_idx == LW'(3); end
            RET_INT: begin
                ret_ok = now_found && now_idx != LW'(2) && now_idx != LW'(3);
            end
        endcase
        do_ret  = run && ret_req && ret_ok;
        bad_ret = run && ret_req && !ret_ok;
        ipend_a = ipend_q;
        if (do_ret) begin
            if (!ret_addr[0]) ipend_a[ret_lvl] = 1'b0;
            if (ret_lvl >= LW'(5) || ret_lvl == LW'(1)) ipend_a[4] = 1'b0;
        end
    end

    // Mask and latch after this cycle's software operations and raises.
    always_comb begin
        if (cli_req)
            imask_a = imask_q & LVL_UNMASK;
        else if (sti_req)
            imask_a = (sti_value & ~LVL_UNMASK) | LVL_UNMASK;
        else if (wr_ok && reg_addr == OFF_MASK)
            imask_a = (reg_wdata[NLVL-1:0] & ~LVL_UNMASK) | LVL_UNMASK;
        else
            imask_a = imask_q;
        req_bits = (evt_req & ~NLVL'(16'h0010)) | (NLVL'(exc_req) << 3);
        ilat_a   = ilat_q | req_bits;
        if (wr_ok && reg_addr == OFF_LAT)
            ilat_a = (ilat_q & ~(reg_wdata[NLVL-1:0] & LVL_W1C_OK)) | req_bits;
    end

    // Take decision on the most urgent latched, unmasked level.
    always_comb begin
        cur_a   = aft_found ? {1'b0, aft_idx} : LVL_USER;
        cand5   = {1'b0, cand_idx};
        do_take = 1'b0;
        dfault  = 1'b0;
        if (run && cand_found) begin
            if (cand5 <= 5'd1)
                do_take = 1'b1;
            else if (cand5 <= 5'd3) begin
                if (cand5 < cur_a) do_take = 1'b1;
                else               dfault  = 1'b1;
            end else if (cand5 >= 5'd5) begin
                if (!(ipend_a[4] && aft_found) &&
                    (cand5 < cur_a || (cand5 == cur_a && selfnest_en)))
                    do_take = 1'b1;
            end
        end
        ipend_n = ipend_a;
        ilat_n  = ilat_a;
        if (do_take) begin
            ipend_n[cand_idx] = 1'b1;
            ilat_n[cand_idx]  = 1'b0;
            if (cand5 >= 5'd5) ipend_n[4] = 1'b1;
        end
        cause_now = exc_req ? exc_cause : cause_q;
        if (cand5 == 5'd3)
            ret_save = (cause_now >= CAUSE_ERR_MIN) ? cur_pc : next_pc;
        else if (cand5 >= 5'd5)
            ret_save = cur_pc | DW'(cand5 == cur_a);
        else
            ret_save = cur_pc;
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:   state_d = dfault ? ST_FAULT : ST_RUN;
            ST_FAULT: state_d = ST_FAULT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            imask_q <= LVL_UNMASK;
            ipend_q <= PEND_RESET;
            ilat_q  <= '0;
            cause_q <= '0;
        end else begin
            state_q <= state_d;
            if (run) begin
                imask_q <= imask_a;
                ipend_q <= ipend_n;
                ilat_q  <= ilat_n;
                if (exc_req) cause_q <= exc_cause;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            take_valid     <= 1'b0;
            take_level     <= '0;
            take_ret_addr  <= '0;
            take_vec_reset <= 1'b0;
            ret_pc_valid   <= 1'b0;
            ret_pc         <= '0;
            ill_res        <= 1'b0;
            cli_old_mask   <= '0;
        end else begin
            take_valid     <= do_take;
            take_level     <= cand_idx;
            take_ret_addr  <= ret_save;
            take_vec_reset <= do_take && LVL_OVR_OK[cand_idx] && ovr_q[cand_idx];
            ret_pc_valid   <= do_ret;
            ret_pc         <= ret_addr & ~DW'(1);
            ill_res        <= bad_ret;
            if (run && cli_req) cli_old_mask <= imask_q;
        end
    end

    always_comb begin
        unique case (reg_addr)
            OFF_OVR:  reg_rdata = ovr_q;
            OFF_MASK: reg_rdata = DW'(imask_q);
            OFF_PEND: reg_rdata = DW'(ipend_q);
            OFF_LAT:  reg_rdata = DW'(ilat_q);
            OFF_PRIO: reg_rdata = prio_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign reg_err    = (reg_wr || reg_rd) && !reg_full_word;
    assign fatal      = (state_q == ST_FAULT);
    assign user_mode  = !now_found;
    assign supervisor = now_found;
    assign cur_level  = now_idx;

    assert_take_sets_gdis_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_valid && take_level >= LW'(5)) |-> (ipend_q[4] && ipend_q[take_level]));
    assert_take_clears_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_valid |-> !ilat_q[take_level]);
    assert_fatal_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |=> fatal);
    assert_no_take_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fatal |-> !take_valid);
    assert_ret_pc_even_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ret_pc_valid |-> !ret_pc[0]);
    assert_ret_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ret_pc_valid && ill_res));
    assert_unmaskable_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (imask_q & LVL_UNMASK) == LVL_UNMASK);
endmodule

// File: tb/event_ctrl_tb.sv
module event_ctrl_tb_top;
    import event_ctrl_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt_req = '0;
    logic        exc_req = 1'b0;
    logic [5:0]  exc_cause = '0;
    logic        selfnest_en = 1'b0;
    logic [31:0] cur_pc = 32'h100;
    logic [31:0] next_pc = 32'h104;
    logic        ret_req = 1'b0;
    logic [1:0]  ret_kind = '0;
    logic [31:0] ret_addr = '0;
    logic        cli_req = 1'b0;
    logic        sti_req = 1'b0;
    logic [15:0] sti_value = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_full_word = 1'b1;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_err, take_valid, take_vec_reset, ret_pc_valid, ill_res;
    logic        fatal, user_mode, supervisor;
    logic [3:0]  take_level, cur_level;
    logic [31:0] take_ret_addr, ret_pc;
    logic [15:0] cli_old_mask;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    event_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .evt_req(evt_req), .exc_req(exc_req),
        .exc_cause(exc_cause), .selfnest_en(selfnest_en), .cur_pc(cur_pc),
        .next_pc(next_pc), .ret_req(ret_req), .ret_kind(ret_kind),
        .ret_addr(ret_addr), .cli_req(cli_req), .sti_req(sti_req),
        .sti_value(sti_value), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_full_word(reg_full_word), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_err(reg_err),
        .take_valid(take_valid), .take_level(take_level),
        .take_ret_addr(take_ret_addr), .take_vec_reset(take_vec_reset),
        .ret_pc_valid(ret_pc_valid), .ret_pc(ret_pc), .ill_res(ill_res),
        .cli_old_mask(cli_old_mask), .fatal(fatal), .user_mode(user_mode),
        .supervisor(supervisor), .cur_level(cur_level)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        reg_rd = 1'b1; reg_addr = a; reg_full_word = 1'b1;
        #1;
        v = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_full_word = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic raise(input logic [15:0] m);
        evt_req = m;
        tick();
        evt_req = '0;
    endtask

    task automatic do_ret(input ret_kind_e k, input logic [31:0] a);
        ret_req = 1'b1; ret_kind = k; ret_addr = a;
        tick();
        ret_req = 1'b0;
    endtask

    task automatic exc(input logic [5:0] c);
        exc_req = 1'b1; exc_cause = c;
        tick();
        exc_req = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(OFF_MASK, v); chk("R1 mask", v, 32'h1F);
        rd(OFF_PEND, v); chk("R1 pending", v, 32'h12);
        rd(OFF_LAT, v);  chk("R1 latch", v, 32'h0);
        chk("R1 fatal", fatal, 0);
        chk("R2 cur_level", cur_level, 1);
        chk("R2 supervisor", supervisor, 1);
    endtask

    task automatic t_leave_reset();
        logic [31:0] v;
        do_ret(RET_INT, 32'h1000);
        chk("R11 ret valid", ret_pc_valid, 1);
        chk("R11 ret pc", ret_pc, 32'h1000);
        rd(OFF_PEND, v); chk("R11 pending", v, 0);
        chk("R2 user", user_mode, 1);
        do_ret(RET_INT, 32'h1000);
        chk("R10 user return ill", ill_res, 1);
        chk("R10 user return no pc", ret_pc_valid, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(OFF_MASK, 32'hFFFF_FFFF); rd(OFF_MASK, v); chk("R3 mask all", v, 32'hFFFF);
        wr(OFF_MASK, 32'h0); rd(OFF_MASK, v); chk("R3 mask keep", v, 32'h1F);
        wr(OFF_PRIO, 32'hFFFF); rd(OFF_PRIO, v); chk("R3 prio", v, 32'h1F);
        wr(OFF_OVR, 32'h1234_5678); rd(OFF_OVR, v); chk("R3 override", v, 32'h1234_5678);
        wr(OFF_PEND, 32'hFFFF); rd(OFF_PEND, v); chk("R4 pending ro", v, 0);
        reg_wr = 1'b1; reg_addr = OFF_MASK; reg_wdata = 32'hFFFF; reg_full_word = 1'b0;
        #1; chk("R4 size err", reg_err, 1);
        tick(); reg_wr = 1'b0; reg_full_word = 1'b1;
        rd(OFF_MASK, v); chk("R4 size no effect", v, 32'h1F);
        raise(16'h0300);
        chk("R6 masked no take", take_valid, 0);
        rd(OFF_LAT, v); chk("R5 latched", v, 32'h300);
        wr(OFF_LAT, 32'h100); rd(OFF_LAT, v); chk("R4 w1c", v, 32'h200);
    endtask

    task automatic t_nesting();
        logic [31:0] v;
        raise(16'h0200);
        chk("R6 masked again", take_valid, 0);
        wr(OFF_MASK, 32'hFFE0);
        chk("R12 take on mask", take_valid, 1);
        chk("R12 level 9", take_level, 9);
        chk("R7 ret addr", take_ret_addr, 32'h100);
        rd(OFF_PEND, v); chk("R7 pending", v, 32'h210);
        rd(OFF_LAT, v);  chk("R7 latch clr", v, 0);
        raise(16'h0080);
        chk("R6 gdis hold", take_valid, 0);
        rd(OFF_LAT, v); chk("R6 held latch", v, 32'h80);
        do_ret(RET_INT, 32'h2000);
        chk("R11 ret 9", ret_pc_valid, 1);
        chk("R12 take after ret", take_valid, 1);
        chk("R12 level 7", take_level, 7);
        rd(OFF_PEND, v); chk("R12 pending", v, 32'h90);
        do_ret(RET_INT, 32'h2001);
        chk("R11 pc lsb clr", ret_pc, 32'h2000);
        rd(OFF_PEND, v); chk("R11 nest keep", v, 32'h80);
        raise(16'h1000);
        chk("R6 lower hold", take_valid, 0);
        raise(16'h0080);
        chk("R6 same no nest", take_valid, 0);
        rd(OFF_LAT, v); chk("R6 latch both", v, 32'h1080);
        selfnest_en = 1'b1;
        tick();
        selfnest_en = 1'b0;
        chk("R6 self nest take", take_valid, 1);
        chk("R7 nest ret addr", take_ret_addr, 32'h101);
        rd(OFF_LAT, v); chk("R7 latch left", v, 32'h1000);
        do_ret(RET_INT, 32'h3000);
        chk("R12 level 12", take_level, 12);
        chk("R12 take 12", take_valid, 1);
        do_ret(RET_INT, 32'h4000);
        chk("R2 back user", user_mode, 1);
    endtask

    task automatic t_simul();
        logic [31:0] v;
        raise(16'h0440);
        chk("R12 lowest wins", take_level, 6);
        rd(OFF_LAT, v); chk("R12 other latched", v, 32'h400);
        do_ret(RET_INT, 32'h10);
        chk("R12 second taken", take_level, 10);
        chk("R12 second valid", take_valid, 1);
        do_ret(RET_INT, 32'h20);
        rd(OFF_PEND, v); chk("R11 empty", v, 0);
    endtask

    task automatic t_exc();
        logic [31:0] v;
        exc(6'h21);
        chk("R5 exc taken", take_level, 3);
        chk("R8 err cause pc", take_ret_addr, 32'h100);
        rd(OFF_PEND, v); chk("R7 exc no gdis", v, 32'h08);
        do_ret(RET_NMI, 32'h500);
        chk("R10 kind mismatch", ill_res, 1);
        do_ret(RET_EXC, 32'h500);
        chk("R10 exc return ok", ret_pc_valid, 1);
        exc(6'h05);
        chk("R8 service next pc", take_ret_addr, 32'h104);
        do_ret(RET_EXC, 32'h600);
        rd(OFF_PEND, v); chk("R11 exc released", v, 0);
    endtask

    task automatic t_override();
        logic [31:0] v;
        wr(OFF_OVR, 32'hFFFF);
        raise(16'h0100);
        chk("R9 override 8", take_vec_reset, 1);
        do_ret(RET_INT, 32'h0);
        raise(16'h0020);
        chk("R9 level 5 take", take_level, 5);
        chk("R9 no override 5", take_vec_reset, 0);
        do_ret(RET_INT, 32'h0);
        raise(16'h0010);
        chk("R6 bit4 ignored", take_valid, 0);
        rd(OFF_LAT, v); chk("R6 bit4 not latched", v, 0);
    endtask

    task automatic t_cli_sti();
        logic [31:0] v;
        cli_req = 1'b1; tick(); cli_req = 1'b0;
        chk("R13 old mask", cli_old_mask, 16'hFFFF);
        rd(OFF_MASK, v); chk("R13 cleared", v, 32'h1F);
        raise(16'h0100);
        chk("R13 masked after clear", take_valid, 0);
        sti_req = 1'b1; sti_value = 16'h0100; tick(); sti_req = 1'b0;
        chk("R12 take on load", take_valid, 1);
        chk("R13 level 8", take_level, 8);
        rd(OFF_MASK, v); chk("R13 loaded", v, 32'h11F);
        do_ret(RET_INT, 32'h0);
    endtask

    task automatic t_fault();
        raise(16'h0004);
        chk("R5 nmi taken", take_level, 2);
        chk("R5 nmi valid", take_valid, 1);
        do_ret(RET_INT, 32'h0);
        chk("R10 rti at nmi", ill_res, 1);
        raise(16'h0002);
        chk("R5 reset level taken", take_level, 1);
        chk("R5 reset valid", take_valid, 1);
        exc(6'h21);
        chk("R5 double fault", fatal, 1);
        chk("R5 no take fault", take_valid, 0);
        raise(16'h0001);
        chk("R5 frozen", take_valid, 0);
        chk("R5 stays fatal", fatal, 1);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_leave_reset();
        t_regs();
        t_nesting();
        t_simul();
        t_exc();
        t_override();
        t_cli_sti();
        t_fault();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule